// File: doc/BRIEF.md
# Symmetry-Folded 7x7 Gabor Convolution Engine

This block computes one output of a 7x7 two-dimensional convolution per window. The kernels come from a Gabor filter bank that has been reshaped so that every kernel follows one of four symmetry classes. The caller supplies a complete 49-pixel window in raster order each cycle, with index 0 at the top-left, index 24 at the centre and index 48 at the bottom-right. With the window it gives a 2-bit symmetry class, which is captured together with that window. The engine does not multiply each tap. It first folds together, with the correct sign, all pixels that share a coefficient magnitude. It then multiplies each folded group by its single coefficient and sums the products.

The coefficients sit in a ten-entry register bank behind a simple write port. One engine can serve all sixteen filters of a bank on a 512x512 image: the caller reloads the coefficients and changes the class between passes. Zero padding at the image borders is supplied as zero-valued pixels by the window former upstream. Results leave through a registered output with a one-cycle valid strobe, at a fixed latency, and a new window may be accepted every cycle.

Top module: `gabor_sym_conv`

## Requirements
- R1: For a captured window, out_data equals the exact signed sum over all 49 taps of pixel times tap weight. Pixels are unsigned and coefficients are signed 16-bit. The tap weight for row r and column c (both 0..6, pixel index 7r+c) is the sign times coefficient slot m. Fold the position into the top-left quadrant as fr = min(r,6-r) and fc = min(c,6-c), then take a = min(fr,fc) and b = max(fr,fc). The slot is m = 4a - a(a-1)/2 + (b-a), which gives slots 0..9 with slot 9 at the centre.
- R2: Class code 0 (fully even) gives every tap a positive sign.
- R3: Class code 1 (diagonal-odd) gives zero weight to both diagonals (|r-3| = |c-3|). The weight is positive where |r-3| > |c-3| and negative where |r-3| < |c-3|.
- R4: Class code 2 (axis-odd) gives zero weight to row 3 and column 3. The weight is positive where (r-3) and (c-3) have the same sign and negative otherwise.
- R5: Class code 3 (point-odd) gives zero weight to row 3, column 3 and both diagonals. Elsewhere its sign is the product of the R3 sign and the R4 sign.
- R6: A window is captured on a rising edge with in_valid high. out_valid is high for exactly one cycle after the second following edge, so the result is visible three edges after capture counting the capture edge. Windows on consecutive cycles yield results on consecutive cycles, in order.
- R7: After reset out_valid and out_data are 0. out_data keeps its last value while out_valid is low, whatever the window inputs do.
- R8: An edge with coef_we high and coef_addr in 0..9 loads coef_data into that slot. Addresses 10..15 change no slot. All slots are 0 after reset.
- R9: A window uses every coefficient write made on or before its capture edge. A write on the edge after capture does not affect that window.
- R10: Slots a class does not use have no effect on its result: slots 0, 4, 7, 9 for code 1; slots 3, 6, 8, 9 for code 2; all but 1, 2, 5 for code 3.
- R11: An all-255 window with every coefficient at -32768 under code 0 yields exactly -409436160, with no overflow of the 31-bit result.
- R12: The class code is taken from the capture edge of each window, so back-to-back windows with different codes each use their own class.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A window is presented this cycle |
| in_pat | input | 2 | Symmetry class code 0..3 |
| in_pix | input | 392 | 49 unsigned 8-bit pixels; pixel i at bits [8i+7:8i] |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 4 | Coefficient slot address |
| coef_data | input | 16 | Signed coefficient value |
| out_valid | output | 1 | Result strobe |
| out_data | output | 31 | Signed convolution result |

## Verification
A coefficient write and a window moving through the pipeline can fall on the same edge, either on the window's capture edge or on the edge where its folded groups are multiplied. The bench forces both cases on the centre slot with class 0, so that a single changed value moves the result by a known multiple of the centre pixel. It then checks that the first write lands in that window and the second does not. It also sends back-to-back windows with alternating class codes to show that the class travels with its own window.

// File: rtl/gsym_pkg.sv
package gsym_pkg;

  typedef enum logic [1:0] {
    SYM_FULL     = 2'd0,
    SYM_DIAG_ODD = 2'd1,
    SYM_AXIS_ODD = 2'd2,
    SYM_POINT    = 2'd3
  } sym_pat_e;

  localparam logic [1:0] TAP_ZERO = 2'b00;
  localparam logic [1:0] TAP_POS  = 2'b01;
  localparam logic [1:0] TAP_NEG  = 2'b11;

  // Coefficient slot shared by raster tap idx of a k x k kernel.
  function automatic int slot_of(input int idx, input int k);
    int h, fr, fc, a, b;
    h  = (k - 1) / 2;
    fr = idx / k;
    fc = idx % k;
    if (fr > h) fr = k - 1 - fr;
    if (fc > h) fc = k - 1 - fc;
    a = (fr < fc) ? fr : fc;
    b = (fr < fc) ? fc : fr;
    return a * (h + 1) - (a * (a - 1)) / 2 + (b - a);
  endfunction

  // Sign code of tap idx under symmetry class pat.
  function automatic logic [1:0] sign_of(input sym_pat_e pat, input int idx, input int k);
    int h, dr, dc, ar, ac;
    logic neg;
    h  = (k - 1) / 2;
    dr = idx / k - h;
    dc = idx % k - h;
    ar = (dr < 0) ? -dr : dr;
    ac = (dc < 0) ? -dc : dc;
    case (pat)
      SYM_FULL: return TAP_POS;
      SYM_DIAG_ODD: begin
        if (ar == ac) return TAP_ZERO;
        return (ar > ac) ? TAP_POS : TAP_NEG;
      end
      SYM_AXIS_ODD: begin
        if (dr == 0 || dc == 0) return TAP_ZERO;
        return ((dr > 0) == (dc > 0)) ? TAP_POS : TAP_NEG;
      end
      default: begin
        if (dr == 0 || dc == 0 || ar == ac) return TAP_ZERO;
        neg = (ar < ac) ^ ((dr > 0) != (dc > 0));
        return neg ? TAP_NEG : TAP_POS;
      end
    endcase
  endfunction

endpackage

// File: rtl/gsym_coef_bank.sv
module gsym_coef_bank #(
  parameter int NSLOT  = 10,
  parameter int COEF_W = 16,
  parameter int AW     = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [COEF_W-1:0]       wr_data,
  output logic [NSLOT*COEF_W-1:0] coef_flat
);

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    logic [COEF_W-1:0] val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              val_q <= '0;
      else if (wr_en && wr_addr == AW'(k))     val_q <= wr_data;
    end
    assign coef_flat[k*COEF_W +: COEF_W] = val_q;
  end

endmodule

// File: rtl/gsym_fold.sv
module gsym_fold
  import gsym_pkg::*;
#(
  parameter int K     = 7,
  parameter int PIX_W = 8,
  parameter int GW    = 15
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  input  logic [1:0]                     in_pat,
  input  logic [K*K*PIX_W-1:0]           in_pix,
  output logic                           fold_vld,
  output logic [1:0]                     fold_pat,
  output logic [((K+1)/2)*((K+3)/2)/2*GW-1:0] fold_grp
);

  localparam int TAPS  = K * K;
  localparam int NSLOT = ((K + 1) / 2) * ((K + 3) / 2) / 2;

  logic [NSLOT*GW-1:0] grp_d;

  for (genvar k = 0; k < NSLOT; k++) begin : g_grp
    logic [GW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int i = 0; i < TAPS; i++) begin
        if (slot_of(i, K) == k) begin
          case (sign_of(sym_pat_e'(in_pat), i, K))
            TAP_POS: acc = acc + GW'(in_pix[i*PIX_W +: PIX_W]);
            TAP_NEG: acc = acc - GW'(in_pix[i*PIX_W +: PIX_W]);
            default: acc = acc;
          endcase
        end
      end
    end
    assign grp_d[k*GW +: GW] = acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fold_vld <= 1'b0;
      fold_pat <= '0;
      fold_grp <= '0;
    end else begin
      fold_vld <= in_valid;
      if (in_valid) begin
        fold_pat <= in_pat;
        fold_grp <= grp_d;
      end
    end
  end

endmodule

// File: rtl/gsym_mac.sv
module gsym_mac #(
  parameter int NSLOT  = 10,
  parameter int GW     = 15,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 31
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fold_vld,
  input  logic [NSLOT*GW-1:0]     fold_grp,
  input  logic [NSLOT*COEF_W-1:0] coef_flat,
  output logic                    prod_vld,
  output logic                    out_valid,
  output logic signed [ACC_W-1:0] out_data
);

  localparam int PW = GW + COEF_W;

  logic signed [PW-1:0]    prod_q [NSLOT];
  logic signed [ACC_W-1:0] total;

  for (genvar k = 0; k < NSLOT; k++) begin : g_mul
    logic signed [GW-1:0]     grp_s;
    logic signed [COEF_W-1:0] cof_s;
    assign grp_s = $signed(fold_grp[k*GW +: GW]);
    assign cof_s = $signed(coef_flat[k*COEF_W +: COEF_W]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        prod_q[k] <= '0;
      else if (fold_vld) prod_q[k] <= PW'(grp_s) * PW'(cof_s);
    end
  end

  always_comb begin
    total = '0;
    for (int k = 0; k < NSLOT; k++) total = total + ACC_W'(prod_q[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_vld  <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      prod_vld  <= fold_vld;
      out_valid <= prod_vld;
      if (prod_vld) out_data <= total;
    end
  end

endmodule

// File: rtl/gabor_sym_conv.sv
module gabor_sym_conv #(
  parameter int K      = 7,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 16,
  localparam int TAPS  = K * K,
  localparam int NSLOT = ((K + 1) / 2) * ((K + 3) / 2) / 2,
  localparam int AW    = $clog2(NSLOT),
  localparam int GW    = PIX_W + $clog2(TAPS) + 1,
  localparam int ACC_W = PIX_W + COEF_W + $clog2(TAPS) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [1:0]               in_pat,
  input  logic [TAPS*PIX_W-1:0]    in_pix,
  input  logic                     coef_we,
  input  logic [AW-1:0]            coef_addr,
  input  logic signed [COEF_W-1:0] coef_data,
  output logic                     out_valid,
  output logic signed [ACC_W-1:0]  out_data
);

  logic                    fold_vld;
  logic [1:0]              fold_pat;
  logic [NSLOT*GW-1:0]     fold_grp;
  logic [NSLOT*COEF_W-1:0] coef_flat;
  logic                    prod_vld;

  gsym_coef_bank #(.NSLOT(NSLOT), .COEF_W(COEF_W), .AW(AW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(coef_we), .wr_addr(coef_addr),
    .wr_data(coef_data), .coef_flat(coef_flat)
  );

  gsym_fold #(.K(K), .PIX_W(PIX_W), .GW(GW)) u_fold (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pat(in_pat),
    .in_pix(in_pix), .fold_vld(fold_vld), .fold_pat(fold_pat),
    .fold_grp(fold_grp)
  );

  gsym_mac #(.NSLOT(NSLOT), .GW(GW), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst_n(rst_n), .fold_vld(fold_vld), .fold_grp(fold_grp),
    .coef_flat(coef_flat), .prod_vld(prod_vld), .out_valid(out_valid),
    .out_data(out_data)
  );

endmodule

// File: rtl/gsym_conv_chk.sv
module gsym_conv_chk #(
  parameter int NSLOT  = 10,
  parameter int GW     = 15,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 31,
  parameter int AW     = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    fold_vld,
  input logic [1:0]              fold_pat,
  input logic [NSLOT*GW-1:0]     fold_grp,
  input logic                    prod_vld,
  input logic                    out_valid,
  input logic [ACC_W-1:0]        out_data,
  input logic                    coef_we,
  input logic [AW-1:0]           coef_addr,
  input logic [NSLOT*COEF_W-1:0] coef_flat
);

  AST_CAPTURE_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> fold_vld);  // R6
  AST_NO_GHOST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !fold_vld);  // R6
  AST_FOLD_TO_PROD: assert property (@(posedge clk) disable iff (!rst_n)
    fold_vld |=> prod_vld);  // R6
  AST_RESULT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    prod_vld |=> out_valid);  // R6
  AST_NO_GHOST_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !prod_vld |=> !out_valid);  // R6
  AST_OUTPUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !prod_vld |=> $stable(out_data));  // R7
  AST_SLOT_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(coef_we && int'(coef_addr) < NSLOT) |=> $stable(coef_flat));  // R8
  AST_CENTRE_NULL: assert property (@(posedge clk) disable iff (!rst_n)
    (fold_vld && fold_pat != 2'd0) |-> fold_grp[(NSLOT-1)*GW +: GW] == '0);  // R10
  AST_CORNER_NULL: assert property (@(posedge clk) disable iff (!rst_n)
    (fold_vld && fold_pat[0]) |-> fold_grp[GW-1:0] == '0);  // R3 R5

endmodule

bind gabor_sym_conv gsym_conv_chk #(
  .NSLOT(NSLOT), .GW(GW), .COEF_W(COEF_W), .ACC_W(ACC_W), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fold_vld(fold_vld),
  .fold_pat(fold_pat), .fold_grp(fold_grp), .prod_vld(prod_vld),
  .out_valid(out_valid), .out_data(out_data), .coef_we(coef_we),
  .coef_addr(coef_addr), .coef_flat(coef_flat)
);

// File: tb/gabor_sym_conv_bench.sv
module gabor_sym_conv_bench;

  localparam int ACC_W = 8 + 16 + $clog2(49) + 1;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    in_valid = 1'b0;
  logic [1:0]              in_pat = '0;
  logic [49*8-1:0]         in_pix = '0;
  logic                    coef_we = 1'b0;
  logic [3:0]              coef_addr = '0;
  logic signed [15:0]      coef_data = '0;
  logic                    out_valid;
  logic signed [ACC_W-1:0] out_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] px [49];
  int         cf [10];
  int         qt [4][4] = '{'{0, 1, 2, 3}, '{1, 4, 5, 6}, '{2, 5, 7, 8}, '{3, 6, 8, 9}};

  gabor_sym_conv u_gabor_sym_conv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pat(in_pat),
    .in_pix(in_pix), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_data(coef_data), .out_valid(out_valid), .out_data(out_data)
  );

  always #10 clk = ~clk;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  task automatic chk(string req, bit ok, longint got, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  // Reference weight of tap (r,c) for class pat, straight from the requirements.
  function automatic int tap_wt(int pat, int r, int c);
    int dv, dh, av, ah, mag, sg;
    dv = r - 3; dh = c - 3;
    av = dv < 0 ? -dv : dv;
    ah = dh < 0 ? -dh : dh;
    mag = cf[qt[3 - av][3 - ah]];
    case (pat)
      0: sg = 1;
      1: sg = (av == ah) ? 0 : (av > ah ? 1 : -1);
      2: sg = (dv == 0 || dh == 0) ? 0 : (dv * dh > 0 ? 1 : -1);
      default: sg = (dv == 0 || dh == 0 || av == ah) ? 0 :
                    (av > ah ? 1 : -1) * (dv * dh > 0 ? 1 : -1);
    endcase
    return sg * mag;
  endfunction

  function automatic longint ref_sum(int pat);
    longint s = 0;
    for (int r = 0; r < 7; r++)
      for (int c = 0; c < 7; c++)
        s += longint'(tap_wt(pat, r, c)) * longint'(px[r*7 + c]);
    return s;
  endfunction

  task automatic fill_px(int seed);
    for (int i = 0; i < 49; i++) px[i] = 8'((i * 37 + seed * 11 + i * i * seed) & 255);
  endtask

  task automatic fill_cf(int seed);
    for (int k = 0; k < 10; k++) cf[k] = ((k * 1237 + seed * 911) % 20000) - 9000;
  endtask

  task automatic drive_win(int pat);
    in_valid = 1'b1;
    in_pat = 2'(pat);
    for (int i = 0; i < 49; i++) in_pix[i*8 +: 8] = px[i];
  endtask

  task automatic write_coef(int a, int d);
    @(negedge clk);
    coef_we = 1'b1; coef_addr = 4'(a); coef_data = 16'(d);
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  task automatic load_all();
    for (int k = 0; k < 10; k++) write_coef(k, cf[k]);
  endtask

  // One window: capture edge, then result after two more edges.
  task automatic run_one(int pat, string req, output longint got);
    longint exp;
    exp = ref_sum(pat);
    @(negedge clk); drive_win(pat);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk); chk({req, " early strobe"}, out_valid == 1'b0, longint'(out_valid), 0);
    @(negedge clk);
    chk({req, " strobe"}, out_valid == 1'b1, longint'(out_valid), 1);
    chk({req, " value"}, longint'(out_data) == exp, longint'(out_data), exp);
    got = longint'(out_data);
    @(negedge clk); chk({req, " strobe width"}, out_valid == 1'b0, longint'(out_valid), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R7 reset valid", out_valid == 1'b0, longint'(out_valid), 0);
    chk("R7 reset data", out_data == '0, longint'(out_data), 0);
    for (int k = 0; k < 10; k++) cf[k] = 0;
    fill_px(3);
    begin longint g; run_one(0, "R8 reset coefficients", g); end
  endtask

  task automatic t_patterns();
    longint g;
    for (int s = 1; s <= 2; s++) begin
      fill_cf(s); load_all(); fill_px(s);
      run_one(0, "R1 R2 class0", g);
      run_one(1, "R3 class1", g);
      run_one(2, "R4 class2", g);
      run_one(3, "R5 class3", g);
    end
    for (int i = 0; i < 49; i++) px[i] = 8'd255;
    run_one(3, "R5 class3 saturated pixels", g);
    run_one(1, "R3 class1 saturated pixels", g);
  endtask

  task automatic t_back_to_back();
    longint exp [4];
    int pats [4] = '{2, 0, 3, 1};
    fill_cf(5); load_all(); fill_px(7);
    for (int j = 0; j < 4; j++) exp[j] = ref_sum(pats[j]);
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      if (k >= 3) begin
        chk("R6 R12 stream strobe", out_valid == 1'b1, longint'(out_valid), 1);
        chk("R12 stream value", longint'(out_data) == exp[k-3], longint'(out_data), exp[k-3]);
      end else begin
        chk("R6 stream idle", out_valid == 1'b0, longint'(out_valid), 0);
      end
      if (k < 4) drive_win(pats[k]); else in_valid = 1'b0;
    end
    @(negedge clk);
    chk("R6 stream end", out_valid == 1'b0, longint'(out_valid), 0);
  endtask

  task automatic t_hold();
    longint g;
    fill_px(9);
    run_one(2, "R7 before hold", g);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      in_pat = 2'(c); in_pix = {49{8'(c * 50 + 7)}};
      chk("R7 hold data", longint'(out_data) == g, longint'(out_data), g);
      chk("R7 hold strobe", out_valid == 1'b0, longint'(out_valid), 0);
    end
  endtask

  task automatic t_coef_race();
    longint exp;
    fill_cf(4); load_all(); fill_px(11);
    cf[9] = 1234;
    exp = ref_sum(0);
    @(negedge clk);
    drive_win(0);
    coef_we = 1'b1; coef_addr = 4'd9; coef_data = 16'sd1234;
    @(negedge clk);
    in_valid = 1'b0;
    coef_data = -16'sd777;
    @(negedge clk);
    coef_we = 1'b0;
    @(negedge clk);
    chk("R9 write order strobe", out_valid == 1'b1, longint'(out_valid), 1);
    chk("R9 same-edge write used, later write not", longint'(out_data) == exp, longint'(out_data), exp);
    cf[9] = -777;
    begin longint g; run_one(0, "R9 later write takes effect", g); end
  endtask

  task automatic t_bad_addr();
    longint g;
    fill_cf(6); load_all(); fill_px(13);
    write_coef(10, 16'h7FFF);
    write_coef(15, -5);
    run_one(0, "R8 out-of-range address ignored", g);
  endtask

  task automatic t_unused();
    longint g0, g1;
    fill_cf(8); load_all(); fill_px(17);
    run_one(3, "R10 class3 base", g0);
    for (int k = 0; k < 10; k++)
      if (k != 1 && k != 2 && k != 5) write_coef(k, 30000 - k * 4321);
    run_one(3, "R10 class3 after unused writes", g1);
    chk("R10 unused slots no effect", g0 == g1, g1, g0);
    fill_cf(9); load_all();
    run_one(2, "R10 class2 base", g0);
    write_coef(3, 111); write_coef(6, -222); write_coef(8, 333); write_coef(9, -444);
    run_one(2, "R10 class2 after unused writes", g1);
    chk("R10 class2 unused slots", g0 == g1, g1, g0);
  endtask

  task automatic t_extreme();
    longint g;
    for (int k = 0; k < 10; k++) cf[k] = -32768;
    load_all();
    for (int i = 0; i < 49; i++) px[i] = 8'd255;
    run_one(0, "R11 extreme", g);
    chk("R11 exact extreme value", g == -64'sd409436160, g, -64'sd409436160);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_patterns();
    t_back_to_back();
    t_hold();
    t_coef_race();
    t_bad_addr();
    t_unused();
    t_extreme();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule